// File: doc/BRIEF.md
# Key-Protected Flash Program Controller

A register-mapped controller that places flash page erase and half-word programming behind a two-byte key code. Software loads a target address and then writes a data word. That data write becomes an erase or a program request to the flash array, but only if the key machine is unlocked. A configuration flag picks between erase and program. A read-only busy flag tracks the request until the array signals completion.

Two unlock modes exist. The one-shot mode allows a single accepted operation and then relocks. The persistent mode stays open until a lock code arrives, and it advances the address by one half-word after each program. A data write that is refused sets a sticky error flag and leaves the flash untouched. A write is refused when the key machine is locked, when the controller is busy, or when the address is odd. The error flag is cleared only through the clear alias of the configuration register.

The flash side is a level request with erase/program select, address and half-word data. The request is held until the array pulses a done input, so the array alone sets the erase and program latencies.

Top module: `flash_key_ctrl`

## Requirements
- R1: After reset the configuration reads 0, the key state register (offset 0xC0, bits 1:0) reads 0 = locked, and no flash request is active.
- R2: The configuration register is read at offsets 0x00, 0x04 and 0x08. A write to 0x00 loads the erase-enable flag (bit 18). A write to 0x04 sets bit 18 when that written bit is 1. A write to 0x08 clears bit 18 and the error flag (bit 0) for each written 1.
- R3: Key byte 0xA5 followed by 0xF1 (low byte of writes to offset 0xC0) gives key state 2 = one-shot. After one accepted data write the state returns to 0.
- R4: Key byte 0xA5 followed by 0xF2 gives key state 3 = persistent. It survives any number of operations and returns to 0 on key byte 0x5A.
- R5: Any key byte other than the one expected next returns the key state to 0. 0xA5 moves to state 1 = armed from every state except armed. In armed state only 0xF1 or 0xF2 is accepted.
- R6: With bit 18 set, an accepted write to the data register (offset 0xB0) erases the page that holds the write address (offset 0xA0), leaving it all ones. The request address is the page base.
- R7: With bit 18 clear, an accepted data write programs the low 16 bits of the written word at the write address. In persistent mode the write address then advances by 2.
- R8: Configuration bit 20 (busy) reads 1 from the cycle after an accepted data write until the cycle after the array's done pulse. The request stays high over the same span.
- R9: A data write while the key state is not 2 or 3 starts no operation and sets error bit 0.
- R10: A data or address write while busy is ignored and sets error bit 0. The held request address does not change.
- R11: A data write while the write address is odd starts no operation, sets error bit 0, and leaves the key state unchanged.
- R12: The error bit stays set through writes to offsets 0x00 and 0x04. Only a write to 0x08 with bit 0 set clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| fl_req | output | 1 | Flash operation request, held until done |
| fl_erase | output | 1 | 1 = page erase, 0 = half-word program |
| fl_addr | output | ADDR_W | Byte address of the operation |
| fl_data | output | 16 | Half-word to program |
| fl_done | input | 1 | One-cycle completion pulse from the array |

## Verification
The bench targets the key sequence corners. A repeated 0xA5 must lock the machine instead of re-arming it. A one-shot unlock must stay open after a refused odd-address write, and a wrong second byte must lock. A design that re-armed or consumed the unlock on the wrong event would either program flash while locked or refuse a legal write. Writes made while busy are checked against the held request and against the address readback, because a design that let them through would corrupt an operation already in flight. Persistent-mode address advance and page-base rounding on erase are checked against a reference copy of the array over a random mix of operations. A wrong increment or wrong page mask shows up there as misplaced half-words.

// File: rtl/flash_key_ctrl.sv
module flash_key_ctrl #(
  parameter int ADDR_W     = 12,
  parameter int PAGE_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              fl_req,
  output logic              fl_erase,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [15:0]       fl_data,
  input  logic              fl_done
);

  localparam int PAGE_LSB = $clog2(PAGE_BYTES);
  localparam int ERASE_B  = 18;
  localparam int BUSY_B   = 20;
  localparam int ERR_B    = 0;

  localparam logic [7:0] OFS_CFG  = 8'h00;
  localparam logic [7:0] OFS_SET  = 8'h04;
  localparam logic [7:0] OFS_CLR  = 8'h08;
  localparam logic [7:0] OFS_ADDR = 8'hA0;
  localparam logic [7:0] OFS_DATA = 8'hB0;
  localparam logic [7:0] OFS_KEY  = 8'hC0;

  localparam logic [7:0] K_ARM    = 8'hA5;
  localparam logic [7:0] K_ONE    = 8'hF1;
  localparam logic [7:0] K_MANY   = 8'hF2;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_ARMED  = 2'd1,
    KS_ONE    = 2'd2,
    KS_MANY   = 2'd3
  } key_t;

  key_t              key_st;
  logic              erase_en;
  logic              err_q;
  logic [ADDR_W-1:0] wr_addr_q;

  wire wr      = bus_sel & bus_wr;
  wire wr_all  = wr && bus_addr == OFS_CFG;
  wire wr_set  = wr && bus_addr == OFS_SET;
  wire wr_clr  = wr && bus_addr == OFS_CLR;
  wire wr_wa   = wr && bus_addr == OFS_ADDR;
  wire wr_wd   = wr && bus_addr == OFS_DATA;
  wire wr_key  = wr && bus_addr == OFS_KEY;
  wire busy    = fl_req;
  wire open_st = key_st == KS_ONE || key_st == KS_MANY;
  wire go      = wr_wd && open_st && !busy && !wr_addr_q[0];
  wire refuse  = (wr_wd && !go) || (wr_wa && busy);

  wire [ADDR_W-1:0] page_base = {wr_addr_q[ADDR_W-1:PAGE_LSB], {PAGE_LSB{1'b0}}};
  wire [31:0] cfg_rd = (32'(erase_en) << ERASE_B) | (32'(busy) << BUSY_B) | (32'(err_q) << ERR_B);
  wire [7:0] kb = bus_wdata[7:0];

  always_comb begin
    case (bus_addr)
      OFS_CFG, OFS_SET, OFS_CLR: bus_rdata = cfg_rd;
      OFS_ADDR:                  bus_rdata = 32'(wr_addr_q);
      OFS_KEY:                   bus_rdata = 32'(key_st);
      default:                   bus_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      erase_en <= 1'b0;
    end else if (wr_all) begin
      erase_en <= bus_wdata[ERASE_B];
    end else if (wr_set && bus_wdata[ERASE_B]) begin
      erase_en <= 1'b1;
    end else if (wr_clr && bus_wdata[ERASE_B]) begin
      erase_en <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (refuse) begin
      err_q <= 1'b1;
    end else if (wr_clr && bus_wdata[ERR_B]) begin
      err_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr_q <= '0;
    end else if (wr_wa && !busy) begin
      wr_addr_q <= bus_wdata[ADDR_W-1:0];
    end else if (go && !erase_en && key_st == KS_MANY) begin
      wr_addr_q <= wr_addr_q + ADDR_W'(2);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_st <= KS_LOCKED;
    end else if (wr_key) begin
      if (key_st == KS_ARMED)
        key_st <= kb == K_ONE ? KS_ONE : kb == K_MANY ? KS_MANY : KS_LOCKED;
      else
        key_st <= kb == K_ARM ? KS_ARMED : KS_LOCKED;
    end else if (go && key_st == KS_ONE) begin
      key_st <= KS_LOCKED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_req   <= 1'b0;
      fl_erase <= 1'b0;
      fl_addr  <= '0;
      fl_data  <= '0;
    end else if (go) begin
      fl_req   <= 1'b1;
      fl_erase <= erase_en;
      fl_addr  <= erase_en ? page_base : wr_addr_q;
      fl_data  <= bus_wdata[15:0];
    end else if (fl_done) begin
      fl_req   <= 1'b0;
    end
  end

endmodule

// File: rtl/flash_key_ctrl_sva.sv
module flash_key_ctrl_sva #(
  parameter int ADDR_W   = 12,
  parameter int PAGE_LSB = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [7:0]        bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              fl_req,
  input logic              fl_erase,
  input logic [ADDR_W-1:0] fl_addr,
  input logic              fl_done,
  input logic [1:0]        key_st,
  input logic              err_q
);

  wire data_wr = bus_sel && bus_wr && bus_addr == 8'hB0;
  wire clr_err = bus_sel && bus_wr && bus_addr == 8'h08 && bus_wdata[0];

  assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req && !fl_done |=> fl_req);

  assert_req_from_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_req) |-> $past(data_wr));

  assert_oneshot_consumed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_req) |-> (key_st == 2'd0 || key_st == 2'd3));

  assert_addr_even_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req && !fl_erase |-> !fl_addr[0]);

  assert_page_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req && fl_erase |-> fl_addr[PAGE_LSB-1:0] == '0);

  assert_addr_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req && $past(fl_req) |-> $stable(fl_addr));

  assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_q) |-> $past(clr_err));

endmodule

bind flash_key_ctrl flash_key_ctrl_sva #(.ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB)) u_sva (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .fl_req(fl_req),
  .fl_erase(fl_erase), .fl_addr(fl_addr), .fl_done(fl_done),
  .key_st(key_st), .err_q(err_q)
);

// File: tb/flash_key_ctrl_tb.sv
module flash_key_ctrl_tb;
  localparam int ADDR_W    = 12;
  localparam int PAGE_B    = 1024;
  localparam int HW        = (1 << ADDR_W) / 2;
  localparam int PAGE_HW   = PAGE_B / 2;
  localparam int ERASE_LAT = 20;
  localparam int PROG_LAT  = 5;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic fl_req, fl_erase, fl_done;
  logic [ADDR_W-1:0] fl_addr;
  logic [15:0] fl_data;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  flash_key_ctrl #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_B)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fl_req(fl_req), .fl_erase(fl_erase), .fl_addr(fl_addr),
    .fl_data(fl_data), .fl_done(fl_done)
  );

  logic [15:0] mem [HW];
  logic [15:0] ref_mem [HW];
  int cnt = 0;
  logic done_r = 0;
  logic [ADDR_W-1:0] last_req_addr;
  assign fl_done = done_r;

  initial for (int i = 0; i < HW; i++) begin mem[i] = 16'hFFFF; ref_mem[i] = 16'hFFFF; end

  always @(posedge clk) begin
    if (fl_req && !$past(fl_req)) last_req_addr <= fl_addr;
    if (done_r) done_r <= 1'b0;
    else if (fl_req) begin
      if (cnt == (fl_erase ? ERASE_LAT : PROG_LAT) - 1) begin
        cnt <= 0;
        done_r <= 1'b1;
        if (fl_erase)
          for (int i = 0; i < PAGE_HW; i++) mem[(int'(fl_addr) >> 1) + i] <= 16'hFFFF;
        else
          mem[int'(fl_addr) >> 1] <= fl_data;
      end else cnt <= cnt + 1;
    end
  end

  function automatic int page_first_hw(input int byte_addr);
    return (byte_addr / PAGE_B) * PAGE_HW;
  endfunction

  function automatic logic [31:0] cfg_val(input bit er, input bit busy, input bit err);
    return (32'(er) << 18) | (32'(busy) << 20) | 32'(err);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 400; i++) begin
      rd(8'h00, v);
      if (!v[20]) return;
      @(negedge clk);
    end
    chk("R8 busy timeout", 1, 0);
  endtask

  task automatic unlock(input bit many);
    wr(8'hC0, 32'hA5);
    wr(8'hC0, many ? 32'hF2 : 32'hF1);
  endtask

  task automatic program_hw(input int a, input logic [15:0] d, input bit many);
    wr(8'h08, 32'h0004_0000);
    wr(8'hA0, a);
    unlock(many);
    wr(8'hB0, {16'hDEAD, d});
    wait_idle();
    ref_mem[a >> 1] = d;
    if (many) wr(8'hC0, 32'h5A);
  endtask

  task automatic erase_page(input int a);
    wr(8'h04, 32'h0004_0000);
    wr(8'hA0, a);
    unlock(0);
    wr(8'hB0, 0);
    wait_idle();
    for (int i = 0; i < PAGE_HW; i++) ref_mem[page_first_hw(a) + i] = 16'hFFFF;
    wr(8'h08, 32'h0004_0000);
  endtask

  function automatic int mem_diffs();
    int n = 0;
    for (int i = 0; i < HW; i++) if (mem[i] !== ref_mem[i]) n++;
    return n;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    rd(8'h00, v); chk("R1 cfg", v, 0);
    rd(8'hC0, v); chk("R1 key", v, 0);
    chk("R1 req", 32'(fl_req), 0);

    wr(8'h04, 32'h0004_0000); rd(8'h08, v); chk("R2 set alias", v, cfg_val(1, 0, 0));
    wr(8'h08, 32'h0004_0000); rd(8'h04, v); chk("R2 clr alias", v, cfg_val(0, 0, 0));
    wr(8'h00, 32'h0004_0000); rd(8'h00, v); chk("R2 plain on", v, cfg_val(1, 0, 0));
    wr(8'h00, 32'h0); rd(8'h00, v); chk("R2 plain off", v, cfg_val(0, 0, 0));

    wr(8'hC0, 32'hA5); rd(8'hC0, v); chk("R5 armed", v, 1);
    wr(8'hC0, 32'h33); rd(8'hC0, v); chk("R5 bad second byte", v, 0);
    wr(8'hC0, 32'hA5); wr(8'hC0, 32'hA5); rd(8'hC0, v); chk("R5 repeated A5", v, 0);

    wr(8'hA0, 32'h40);
    wr(8'hB0, 32'h1111);
    chk("R9 no request", 32'(fl_req), 0);
    rd(8'h00, v); chk("R9 error set", v, cfg_val(0, 0, 1));
    repeat (PROG_LAT + 2) @(negedge clk);
    chk("R9 flash untouched", 32'(mem[32'h40 >> 1]), 32'hFFFF);

    wr(8'h04, 32'h1); wr(8'h00, 32'h0);
    rd(8'h00, v); chk("R12 survives set/plain", v, cfg_val(0, 0, 1));
    wr(8'h08, 32'h1); rd(8'h00, v); chk("R12 clear alias", v, cfg_val(0, 0, 0));

    wr(8'hA0, 32'h10);
    unlock(0);
    rd(8'hC0, v); chk("R3 one-shot state", v, 2);
    wr(8'hB0, 32'h1234_ABCD);
    rd(8'h00, v); chk("R8 busy after accept", v, cfg_val(0, 1, 0));
    rd(8'hC0, v); chk("R3 relocked", v, 0);
    wait_idle();
    ref_mem[8] = 16'hABCD;
    chk("R7 programmed", 32'(mem[8]), 32'hABCD);
    rd(8'hA0, v); chk("R7 no advance one-shot", v, 32'h10);

    wr(8'hA0, 32'h100);
    unlock(1);
    wr(8'hB0, 32'h0000_5555);
    wr(8'hB0, 32'h0000_6666);
    rd(8'h00, v); chk("R10 data while busy", v, cfg_val(0, 1, 1));
    wr(8'hA0, 32'h300);
    rd(8'hA0, v); chk("R10 addr while busy", v, 32'h102);
    chk("R10 held address", 32'(fl_addr), 32'h100);
    wait_idle();
    ref_mem[32'h100 >> 1] = 16'h5555;
    wr(8'h08, 32'h1);
    for (int i = 0; i < 4; i++) begin
      wr(8'hB0, 32'h7000 + i);
      wait_idle();
      ref_mem[(32'h102 >> 1) + i] = 16'(32'h7000 + i);
    end
    rd(8'hC0, v); chk("R4 persists", v, 3);
    rd(8'hA0, v); chk("R7 auto advance", v, 32'h10A);
    chk("R7 consecutive", 32'(mem[(32'h108) >> 1]), 32'h7003);

    wr(8'hA0, 32'h21);
    wr(8'hB0, 32'h9999);
    chk("R11 no request", 32'(fl_req), 0);
    rd(8'h00, v); chk("R11 error", v, cfg_val(0, 0, 1));
    rd(8'hC0, v); chk("R11 key kept", v, 3);
    wr(8'hC0, 32'h5A); rd(8'hC0, v); chk("R4 lock code", v, 0);
    wr(8'h08, 32'h1);

    wr(8'hA0, 32'h21);
    unlock(0);
    wr(8'hB0, 32'h4444);
    rd(8'hC0, v); chk("R11 one-shot kept", v, 2);
    wr(8'hA0, 32'h22);
    wr(8'hB0, 32'h4444);
    wait_idle();
    ref_mem[32'h22 >> 1] = 16'h4444;
    wr(8'h08, 32'h1);

    program_hw(32'h402, 16'h0BAD, 0);
    program_hw(32'h7FE, 16'hCAFE, 0);
    erase_page(32'h5A6);
    chk("R6 request at page base", 32'(last_req_addr), 32'h400);
    chk("R6 page erased", 32'(mem[32'h402 >> 1]), 32'hFFFF);
    chk("R6 page end erased", 32'(mem[32'h7FE >> 1]), 32'hFFFF);
    chk("R6 other page intact", 32'(mem[8]), 32'hABCD);

    for (int it = 0; it < 120; it++) begin
      int sel = $urandom_range(0, 9);
      int a = $urandom_range(0, HW - 1) * 2;
      if (sel == 0) erase_page(a);
      else if (sel == 1) begin
        logic [7:0] bad = 8'($urandom);
        if (bad == 8'hF1 || bad == 8'hF2 || bad == 8'hA5) bad = 8'h00;
        wr(8'hA0, a);
        wr(8'hC0, 32'hA5);
        wr(8'hC0, 32'(bad));
        wr(8'hB0, $urandom);
        rd(8'h00, v); chk("R5 random bad key refused", v, cfg_val(0, 0, 1));
        wr(8'h08, 32'h1);
      end else program_hw(a, 16'($urandom), sel > 5);
    end
    repeat (4) @(negedge clk);
    chk("R7 random array compare", 32'(mem_diffs()), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule